// File: doc/BRIEF.md
# SDRAM command legality checker

This block sits passively on the command pins of a two-bank synchronous DRAM. On every clock edge it turns chip select, the three strobes, clock enable and two address bits into a command. It keeps a state machine for each bank and a power and refresh state for the device. Any command that the current state does not allow raises a one-cycle error pulse with a code. It drives nothing on the bus. It is intended for a verification environment or a debug monitor next to a memory controller.

Address bit 9 (`a_bank`) picks the bank. Address bit 8 (`a_ap`) asks for auto-precharge on a read or write, and selects both banks on a precharge. Minimum spacings are set as clock counts:

- `T_RCD`: activate to read or write.
- `T_RAS`: activate to precharge.
- `T_RP`: precharge duration.
- `T_RFC`: refresh duration.
- `BURST_LEN`: burst length.

Clock enable is tracked in three ways. A low clock enable with both banks idle is power-down. A low clock enable during a burst freezes the burst (clock suspend). A refresh issued together with a low clock enable starts self-refresh.

Top module: `sdram_cmd_guard`

## Requirements
- R1: The pins {cs_n,ras_n,cas_n,we_n} decode as follows:
  - 1xxx is DESELECT (code 0).
  - 0111 is NOP (1).
  - 0011 is ACTIVATE (2).
  - 0101 is READ (3).
  - 0100 is WRITE (4).
  - 0010 is PRECHARGE (5).
  - 0001 is REFRESH (6).
  - 0000 is MODE SET (7).
  - 0110 is BURST STOP (8).
  - `cmd_o` shows the code one cycle after the edge that samples the pins.
- R2: ACTIVATE moves an idle bank to row-open (state 1). ACTIVATE to a bank that is not idle (state 0) gives error code 1 (wrong state) and leaves the bank unchanged.
- R3: READ or WRITE to an idle bank gives code 1. Issued fewer than `T_RCD` edges after the ACTIVATE, it gives code 2 (too early). A legal READ or WRITE without auto-precharge shows state 2 (read) or 3 (write) for `BURST_LEN` cycles, then returns to state 1. BURST STOP returns a bursting bank to state 1 at once.
- R4: READ or WRITE with `a_ap` high shows state 4 or 5 for `BURST_LEN` cycles, then state 6 (precharging) for `T_RP` cycles, then state 0. READ, WRITE or PRECHARGE aimed at a bank in state 4 or 5 gives code 1.
- R5: PRECHARGE closes the bank chosen by `a_bank`, or both banks when `a_ap` is high. The bank shows state 6 for `T_RP` cycles and then state 0. A PRECHARGE fewer than `T_RAS` edges after ACTIVATE gives code 2 and is not applied.
- R6: REFRESH and MODE SET need both banks idle, otherwise they give code 1. REFRESH makes `pwr_mode_o` read 4 for `T_RFC` cycles. Any command other than NOP or DESELECT issued while it reads 4 gives code 2 and is not applied.
- R7: `cke` low on an active edge outside a burst enters power-down (`pwr_mode_o` = 1). If a bank is open or a refresh is running, this also gives code 3.
- R8: `cke` low during a burst enters clock suspend (`pwr_mode_o` = 2). The burst count freezes from the next edge until one edge after `cke` is high again.
- R9: REFRESH with `cke` low decodes as self-refresh (code 10) and gives `pwr_mode_o` = 3. When `cke` returns high, the block shows the refresh-busy mode (4) for `T_RFC` cycles.
- R10: While in power-down, suspend or self-refresh, including the exit edge, the command pins are ignored. `cmd_o` reads 9, no error is raised, and the bank states do not change.
- R11: `err_o` is high exactly in the cycle after an offending command, with `err_code_o` non-zero. Priority is wrong state (1), then too early (2), then clock-enable rule (3). An illegal command never changes bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| a_ap | input | 1 | Address bit 8: auto-precharge / all banks |
| a_bank | input | 1 | Address bit 9: bank select |
| cmd_o | output | 4 | Decoded command code |
| err_o | output | 1 | Illegal-command pulse |
| err_code_o | output | 2 | Error kind |
| bank0_state_o | output | 3 | State of bank 0 |
| bank1_state_o | output | 3 | State of bank 1 |
| pwr_mode_o | output | 3 | 0 run, 1 power-down, 2 suspend, 3 self-refresh, 4 refresh busy |

## Verification
The assertions assume that `rst_n` is asserted before any command is judged. They also assume that `T_RFC` and `T_RP` are at least one, so that every timed state is actually visible for a cycle.

The stimulus changes the pins only on falling clock edges, so every command is a clean single-edge sample. Illegal commands appear only where a check expects them. Each clock-enable excursion is driven as a complete entry and exit, so the bank states stay defined after every low-power episode.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_ACT   = 4'd2,
    CMD_READ  = 4'd3,
    CMD_WRITE = 4'd4,
    CMD_PRE   = 4'd5,
    CMD_REF   = 4'd6,
    CMD_MRS   = 4'd7,
    CMD_BST   = 4'd8,
    CMD_HOLD  = 4'd9,
    CMD_SREF  = 4'd10
  } cmd_e;

  typedef enum logic [2:0] {
    B_IDLE     = 3'd0,
    B_ACTIVE   = 3'd1,
    B_READ     = 3'd2,
    B_WRITE    = 3'd3,
    B_READ_AP  = 3'd4,
    B_WRITE_AP = 3'd5,
    B_PRECHG   = 3'd6
  } bank_e;

  typedef enum logic [2:0] {
    PW_RUN     = 3'd0,
    PW_PDOWN   = 3'd1,
    PW_SUSPEND = 3'd2,
    PW_SELF    = 3'd3,
    PW_REFRESH = 3'd4
  } pwr_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_STATE = 2'd1,
    ERR_EARLY = 2'd2,
    ERR_CKE   = 2'd3
  } err_e;

  // Pin pattern to command; chip select high wins over everything else.
  function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) begin
      c = CMD_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  c = CMD_NOP;
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_READ;
        3'b100:  c = CMD_WRITE;
        3'b010:  c = CMD_PRE;
        3'b001:  c = CMD_REF;
        3'b000:  c = CMD_MRS;
        default: c = CMD_BST;
      endcase
    end
    return c;
  endfunction

  // Error merge with fixed priority: state, then spacing, then clock enable.
  function automatic err_e pick_error(input logic wrong, input logic early,
                                      input logic cke_bad);
    if (wrong)        return ERR_STATE;
    else if (early)   return ERR_EARLY;
    else if (cke_bad) return ERR_CKE;
    else              return ERR_NONE;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_guard_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  input  logic run,
  output cmd_e cmd_o
);

  cmd_e raw_cmd;

  always_comb begin
    raw_cmd = decode_pins(cs_n, ras_n, cas_n, we_n);
    if (!run) begin
      cmd_o = CMD_HOLD;
    end else if (raw_cmd == CMD_REF && !cke) begin
      cmd_o = CMD_SREF;
    end else begin
      cmd_o = raw_cmd;
    end
  end

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_guard_pkg::*;
#(
  parameter int T_RCD     = 2,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 2,
  parameter int BURST_LEN = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hold,
  input  logic  do_act,
  input  logic  do_rd,
  input  logic  do_wr,
  input  logic  do_ap,
  input  logic  do_pre,
  input  logic  do_bst,
  output bank_e state_o,
  output logic  wrong_o,
  output logic  early_o,
  output logic  idle_o,
  output logic  burst_o
);

  localparam int AGE_MAX  = (T_RAS > T_RCD) ? T_RAS : T_RCD;
  localparam int AGE_W    = $clog2(AGE_MAX + 1);
  localparam int LEFT_MAX = (BURST_LEN > T_RP) ? BURST_LEN : T_RP;
  localparam int LEFT_W   = $clog2(LEFT_MAX + 1);

  bank_e             state;
  logic [AGE_W-1:0]  age;
  logic [LEFT_W-1:0] left;

  // Saturating count of active edges since the row was opened.
  function automatic logic [AGE_W-1:0] age_step(input logic [AGE_W-1:0] a);
    return (int'(a) >= AGE_MAX) ? a : a + 1'b1;
  endfunction

  function automatic logic spacing_met(input logic [AGE_W-1:0] a, input int lim);
    return int'(a) >= lim;
  endfunction

  logic in_burst, is_ap, row_open, rw, go;

  always_comb begin
    in_burst = state inside {B_READ, B_WRITE, B_READ_AP, B_WRITE_AP};
    is_ap    = state inside {B_READ_AP, B_WRITE_AP};
    row_open = state inside {B_ACTIVE, B_READ, B_WRITE};
    rw       = do_rd | do_wr;
    wrong_o  = (do_act && state != B_IDLE) ||
               (rw && !row_open) ||
               (do_pre && is_ap);
    early_o  = !wrong_o &&
               ((rw && row_open && !spacing_met(age, T_RCD)) ||
                (do_pre && row_open && !spacing_met(age, T_RAS)));
    go       = !wrong_o && !early_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= B_IDLE;
      age   <= '0;
      left  <= '0;
    end else if (!hold) begin
      age <= age_step(age);
      if (do_act && go) begin
        state <= B_ACTIVE;
        age   <= AGE_W'(1);
      end else if (rw && go) begin
        if (do_rd) state <= do_ap ? B_READ_AP : B_READ;
        else       state <= do_ap ? B_WRITE_AP : B_WRITE;
        left <= LEFT_W'(BURST_LEN);
      end else if (do_pre && go && row_open) begin
        state <= B_PRECHG;
        left  <= LEFT_W'(T_RP);
      end else if (do_bst && (state == B_READ || state == B_WRITE)) begin
        state <= B_ACTIVE;
        left  <= '0;
      end else if (in_burst || state == B_PRECHG) begin
        if (left <= LEFT_W'(1)) begin
          if (is_ap) begin
            state <= B_PRECHG;
            left  <= LEFT_W'(T_RP);
          end else begin
            state <= (state == B_PRECHG) ? B_IDLE : B_ACTIVE;
            left  <= '0;
          end
        end else begin
          left <= left - 1'b1;
        end
      end
    end
  end

  assign state_o = state;
  assign idle_o  = (state == B_IDLE);
  assign burst_o = in_burst;

  p_idle_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == B_IDLE |=> state inside {B_IDLE, B_ACTIVE});

  p_ap_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state == B_READ_AP |=> state inside {B_READ_AP, B_PRECHG});

  p_prechg_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state == B_PRECHG |=> state inside {B_PRECHG, B_IDLE});

  p_hold_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(state));

endmodule

// File: rtl/sdram_pwr_track.sv
module sdram_pwr_track
  import sdram_guard_pkg::*;
#(
  parameter int T_RFC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  cmd_e cmd,
  input  logic cke,
  input  logic all_idle,
  input  logic any_burst,
  output logic run_o,
  output logic busy_o,
  output pwr_e pmode_o,
  output logic g_wrong_o,
  output logic g_early_o,
  output logic cke_bad_o
);

  localparam int RFC_W = $clog2(T_RFC + 1);

  pwr_e             pmode_q;
  logic [RFC_W-1:0] rfc;
  logic             busy, run, ref_go;

  always_comb begin
    run       = (pmode_q == PW_RUN);
    busy      = (rfc != '0);
    g_early_o = run && busy && !(cmd inside {CMD_DESEL, CMD_NOP});
    g_wrong_o = run && !busy && (cmd inside {CMD_REF, CMD_MRS, CMD_SREF}) && !all_idle;
    cke_bad_o = run && !cke && cmd != CMD_SREF && !any_burst && (!all_idle || busy);
    ref_go    = run && !busy && cmd == CMD_REF && all_idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmode_q <= PW_RUN;
      rfc     <= '0;
    end else if (run) begin
      if (ref_go)    rfc <= RFC_W'(T_RFC);
      else if (busy) rfc <= rfc - 1'b1;
      if (!cke) begin
        if (cmd == CMD_SREF) pmode_q <= PW_SELF;
        else if (any_burst)  pmode_q <= PW_SUSPEND;
        else                 pmode_q <= PW_PDOWN;
      end
    end else if (cke) begin
      pmode_q <= PW_RUN;
      if (pmode_q == PW_SELF) rfc <= RFC_W'(T_RFC);
    end
  end

  assign run_o   = run;
  assign busy_o  = busy;
  assign pmode_o = (run && busy) ? PW_REFRESH : pmode_q;

  p_self_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pmode_q == PW_SELF && cke) |=> (pmode_q == PW_RUN && busy));

  p_refresh_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && busy && cmd == CMD_ACT) |-> g_early_o);

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdram_guard_pkg::*;
#(
  parameter int T_RCD     = 2,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 2,
  parameter int T_RFC     = 6,
  parameter int BURST_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       cke,
  input  logic       a_ap,
  input  logic       a_bank,
  output logic [3:0] cmd_o,
  output logic       err_o,
  output logic [1:0] err_code_o,
  output logic [2:0] bank0_state_o,
  output logic [2:0] bank1_state_o,
  output logic [2:0] pwr_mode_o
);

  localparam int NBANK = 2;

  cmd_e             cmd;
  logic             run, busy, eff;
  logic             g_wrong, g_early, cke_bad;
  pwr_e             pmode;
  bank_e            st       [NBANK];
  logic [NBANK-1:0] b_wrong, b_early, b_idle, b_burst;
  logic [NBANK-1:0] s_act, s_rd, s_wr, s_pre;
  logic             s_bst;
  err_e             err_now;
  cmd_e             cmd_q;
  err_e             err_q;

  sdram_cmd_decode i_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cke   (cke),
    .run   (run),
    .cmd_o (cmd)
  );

  sdram_pwr_track #(.T_RFC(T_RFC)) i_pwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .cke       (cke),
    .all_idle  (&b_idle),
    .any_burst (|b_burst),
    .run_o     (run),
    .busy_o    (busy),
    .pmode_o   (pmode),
    .g_wrong_o (g_wrong),
    .g_early_o (g_early),
    .cke_bad_o (cke_bad)
  );

  assign eff   = run && !busy;
  assign s_bst = eff && cmd == CMD_BST;

  for (genvar gi = 0; gi < NBANK; gi++) begin : g_bank
    logic hit;
    assign hit       = (a_bank == gi[0]);
    assign s_act[gi] = eff && cmd == CMD_ACT   && hit;
    assign s_rd[gi]  = eff && cmd == CMD_READ  && hit;
    assign s_wr[gi]  = eff && cmd == CMD_WRITE && hit;
    assign s_pre[gi] = eff && cmd == CMD_PRE   && (hit || a_ap);

    sdram_bank_track #(
      .T_RCD     (T_RCD),
      .T_RAS     (T_RAS),
      .T_RP      (T_RP),
      .BURST_LEN (BURST_LEN)
    ) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (!run),
      .do_act  (s_act[gi]),
      .do_rd   (s_rd[gi]),
      .do_wr   (s_wr[gi]),
      .do_ap   (a_ap),
      .do_pre  (s_pre[gi]),
      .do_bst  (s_bst),
      .state_o (st[gi]),
      .wrong_o (b_wrong[gi]),
      .early_o (b_early[gi]),
      .idle_o  (b_idle[gi]),
      .burst_o (b_burst[gi])
    );
  end

  assign err_now = pick_error(g_wrong || (|b_wrong), g_early || (|b_early), cke_bad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_DESEL;
      err_q <= ERR_NONE;
    end else begin
      cmd_q <= cmd;
      err_q <= err_now;
    end
  end

  assign cmd_o         = cmd_q;
  assign err_code_o    = err_q;
  assign err_o         = (err_q != ERR_NONE);
  assign bank0_state_o = st[0];
  assign bank1_state_o = st[1];
  assign pwr_mode_o    = pmode;

  p_pdown_needs_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pmode == PW_PDOWN && $past(pmode) == PW_RUN && err_q == ERR_NONE)
      |-> (st[0] == B_IDLE && st[1] == B_IDLE));

  p_lowpower_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cmd_q == CMD_HOLD && err_q == ERR_NONE));

  p_rw_idle_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !busy && cmd == CMD_READ && st[0] == B_IDLE && !a_bank)
      |=> (err_q == ERR_STATE && st[0] == B_IDLE));

endmodule

// File: tb/test_sdram_cmd_guard.sv
module test_sdram_cmd_guard;

  localparam logic [3:0] P_DES = 4'b1111, P_NOP = 4'b0111, P_ACT = 4'b0011,
                         P_RD  = 4'b0101, P_WR  = 4'b0100, P_PRE = 4'b0010,
                         P_REF = 4'b0001, P_MRS = 4'b0000, P_BST = 4'b0110;
  localparam int X = -1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic cke = 1'b1, a_ap = 1'b0, a_bank = 1'b0;
  logic [3:0] cmd_o;
  logic       err_o;
  logic [1:0] err_code_o;
  logic [2:0] bank0_state_o, bank1_state_o, pwr_mode_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    string tag;
    int    cmd;
    int    err;
    int    s0;
    int    s1;
    int    pm;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  sdram_cmd_guard i_sdram_cmd_guard (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .a_ap(a_ap), .a_bank(a_bank), .cmd_o(cmd_o),
    .err_o(err_o), .err_code_o(err_code_o), .bank0_state_o(bank0_state_o),
    .bank1_state_o(bank1_state_o), .pwr_mode_o(pwr_mode_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    if (exp < 0) return;
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Driver: one command per cycle, expectation for the outputs after that edge.
  task automatic step(input logic [3:0] pins, input logic bk, input logic ap,
                      input logic ck, input string tag, input int ecmd,
                      input int eerr, input int es0, input int es1, input int epm);
    exp_t e;
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = pins;
    a_bank = bk;
    a_ap   = ap;
    cke    = ck;
    e.tag = tag; e.cmd = ecmd; e.err = eerr; e.s0 = es0; e.s1 = es1; e.pm = epm;
    sb.push_back(e);
  endtask

  // Monitor: pops one expectation per edge and compares.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "cmd_o", int'(cmd_o), e.cmd);
        check(e.tag, "err_code_o", int'(err_code_o), e.err);
        if (e.err >= 0) check(e.tag, "err_o", int'(err_o), (e.err != 0) ? 1 : 0);
        check(e.tag, "bank0_state_o", int'(bank0_state_o), e.s0);
        check(e.tag, "bank1_state_o", int'(bank1_state_o), e.s1);
        check(e.tag, "pwr_mode_o", int'(pwr_mode_o), e.pm);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", "cmd_o", int'(cmd_o), 0);
    check("R11 reset", "err_o", int'(err_o), 0);
    check("R2 reset", "bank0_state_o", int'(bank0_state_o), 0);
    check("R2 reset", "bank1_state_o", int'(bank1_state_o), 0);
    check("R7 reset", "pwr_mode_o", int'(pwr_mode_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // decode and basic bank flow
    step(P_DES, 0, 0, 1, "R1 deselect",        0, 0, 0, 0, 0);
    step(P_NOP, 0, 0, 1, "R1 nop",             1, 0, 0, 0, 0);
    step(P_RD,  0, 0, 1, "R3 read idle",       3, 1, 0, 0, 0);
    step(P_BST, 0, 0, 1, "R1 burst stop",      8, 0, 0, 0, 0);
    step(P_ACT, 0, 0, 1, "R2 activate",        2, 0, 1, 0, 0);
    step(P_RD,  0, 0, 1, "R3 read too early",  3, 2, 1, 0, X);
    step(P_ACT, 0, 0, 1, "R2/R11 act open",    2, 1, 1, 0, X);
    step(P_RD,  0, 0, 1, "R3 read legal",      3, 0, 2, 0, X);
    step(P_NOP, 0, 0, 1, "R3 burst",           1, 0, 2, X, X);
    step(P_NOP, 0, 0, 1, "R3 burst",           1, 0, 2, X, X);
    step(P_NOP, 0, 0, 1, "R3 burst last",      1, 0, 2, X, X);
    step(P_NOP, 0, 0, 1, "R3 burst end",       1, 0, 1, X, X);
    step(P_WR,  0, 0, 1, "R3 write",           4, 0, 3, X, X);
    step(P_BST, 0, 0, 1, "R3 stop write",      8, 0, 1, 0, X);

    // bank 1: spacing and auto-precharge
    step(P_ACT, 1, 0, 1, "R2 act bank1",       2, 0, 1, 1, X);
    step(P_PRE, 1, 0, 1, "R5 pre too early",   5, 2, 1, 1, X);
    step(P_RD,  1, 1, 1, "R4 read autopre",    3, 0, 1, 4, X);
    step(P_RD,  1, 0, 1, "R4 read during ap",  3, 1, X, 4, X);
    step(P_NOP, 0, 0, 1, "R4 ap burst",        1, 0, X, 4, X);
    step(P_NOP, 0, 0, 1, "R4 ap burst last",   1, 0, X, 4, X);
    step(P_NOP, 0, 0, 1, "R4 ap precharging",  1, 0, X, 6, X);
    step(P_NOP, 0, 0, 1, "R4 ap precharging",  1, 0, X, 6, X);
    step(P_NOP, 0, 0, 1, "R4 ap idle",         1, 0, 1, 0, X);

    // refresh and mode set
    step(P_REF, 0, 0, 1, "R6 refresh open",    6, 1, 1, 0, 0);
    step(P_MRS, 0, 0, 1, "R6 mode set open",   7, 1, 1, 0, 0);
    step(P_PRE, 0, 1, 1, "R5 precharge all",   5, 0, 6, 0, X);
    step(P_NOP, 0, 0, 1, "R5 precharging",     1, 0, 6, X, X);
    step(P_NOP, 0, 0, 1, "R5 closed",          1, 0, 0, 0, X);
    step(P_MRS, 0, 0, 1, "R6 mode set idle",   7, 0, 0, 0, 0);
    step(P_REF, 0, 0, 1, "R6 refresh",         6, 0, 0, 0, 4);
    step(P_ACT, 0, 0, 1, "R6 act in refresh",  2, 2, 0, 0, 4);
    step(P_NOP, 0, 0, 1, "R6 busy",            1, 0, X, X, 4);
    step(P_NOP, 0, 0, 1, "R6 busy",            1, 0, X, X, 4);
    step(P_NOP, 0, 0, 1, "R6 busy",            1, 0, X, X, 4);
    step(P_NOP, 0, 0, 1, "R6 busy last",       1, 0, X, X, 4);
    step(P_NOP, 0, 0, 1, "R6 refresh done",    1, 0, 0, 0, 0);

    // power-down
    step(P_ACT, 0, 0, 1, "R2 act",             2, 0, 1, 0, 0);
    step(P_NOP, 0, 0, 0, "R7 pdown open row",  1, 3, 1, 0, 1);
    step(P_ACT, 1, 0, 1, "R10 exit ignored",   9, 0, 1, 0, 0);
    step(P_NOP, 0, 0, 1, "R5 wait",            1, 0, X, X, X);
    step(P_NOP, 0, 0, 1, "R5 wait",            1, 0, X, X, X);
    step(P_NOP, 0, 0, 1, "R5 wait",            1, 0, 1, X, X);
    step(P_PRE, 0, 0, 1, "R5 precharge",       5, 0, 6, 0, X);
    step(P_NOP, 0, 0, 1, "R5 precharging",     1, 0, 6, X, X);
    step(P_NOP, 0, 0, 1, "R5 idle",            1, 0, 0, X, X);
    step(P_NOP, 0, 0, 0, "R7 pdown legal",     1, 0, 0, 0, 1);
    step(P_ACT, 0, 0, 0, "R10 pdown ignored",  9, 0, 0, 0, 1);
    step(P_NOP, 0, 0, 1, "R7 pdown exit",      9, 0, 0, 0, 0);

    // clock suspend during write burst
    step(P_ACT, 0, 0, 1, "R2 act",             2, 0, 1, X, X);
    step(P_NOP, 0, 0, 1, "R8 wait",            1, 0, X, X, X);
    step(P_NOP, 0, 0, 1, "R8 wait",            1, 0, X, X, X);
    step(P_WR,  0, 0, 1, "R8 write",           4, 0, 3, X, 0);
    step(P_NOP, 0, 0, 0, "R8 suspend",         1, 0, 3, X, 2);
    step(P_BST, 0, 0, 0, "R10 stop ignored",   9, 0, 3, X, 2);
    step(P_NOP, 0, 0, 0, "R8 suspended",       9, 0, 3, X, 2);
    step(P_NOP, 0, 0, 1, "R8 suspend exit",    9, 0, 3, X, 0);
    step(P_NOP, 0, 0, 1, "R8 resumed",         1, 0, 3, X, X);
    step(P_NOP, 0, 0, 1, "R8 burst last",      1, 0, 3, X, X);
    step(P_NOP, 0, 0, 1, "R8 burst end",       1, 0, 1, X, X);

    // self-refresh
    step(P_PRE, 0, 0, 1, "R5 precharge",       5, 0, 6, X, X);
    step(P_NOP, 0, 0, 1, "R5 precharging",     1, 0, X, X, X);
    step(P_NOP, 0, 0, 1, "R5 idle",            1, 0, 0, 0, X);
    step(P_REF, 0, 0, 0, "R9 self refresh",   10, 0, 0, 0, 3);
    step(P_ACT, 0, 0, 0, "R10 self ignored",   9, 0, 0, 0, 3);
    step(P_NOP, 0, 0, 1, "R9 self exit",       9, 0, 0, 0, 4);
    step(P_NOP, 0, 0, 1, "R9 recovery",        1, 0, X, X, 4);
    step(P_NOP, 0, 0, 1, "R9 recovery",        1, 0, X, X, 4);
    step(P_NOP, 0, 0, 1, "R9 recovery",        1, 0, X, X, 4);
    step(P_NOP, 0, 0, 1, "R9 recovery",        1, 0, X, X, 4);
    step(P_NOP, 0, 0, 1, "R9 recovery last",   1, 0, X, X, 4);
    step(P_NOP, 0, 0, 1, "R9 recovered",       1, 0, 0, 0, 0);

    while (sb.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule